// File: doc/BRIEF.md
# Four-Port I/O Register Decoder

This block sits on the peripheral side of a simple CPU bus. The bus has an 8-bit address, an 8-bit write-data path, an 8-bit read-data path, and separate read and write strobes. The block answers to a group of four consecutive port addresses, 0xF8 through 0xFB. Each port holds one 8-bit register. A write strobe aimed at a port loads the bus data into that port's register on the next clock edge.

A read strobe aimed at a port returns that port's register on the read-data output in the same cycle. Any read that no port answers returns 0xFF, which is what a pulled-up, undriven bus would show. The upper six address bits select the port group. The lower two bits pick one port inside it. The decoder feeds a multiplexer through a one-hot select instead of internal tri-state drivers.

Top module: `pmio_decoder`

## Requirements
- R1: A synchronous active-high reset clears all four port registers to 0x00. A read of any port right after reset returns 0x00.
- R2: When the write strobe is high, the read strobe is low and the address is 0xF8+i (i = 0..3), port i loads the write data at that clock edge. The new value can be read from the next cycle on.
- R3: When the read strobe is high, the write strobe is low and the address is 0xF8+i, the read data equals port i's register in the same cycle, with no clock delay.
- R4: A read of any address outside 0xF8..0xFB returns 0xFF.
- R5: While the read strobe is low, the read data is 0xFF.
- R6: A write to an address outside 0xF8..0xFB changes no port register. This includes addresses such as 0xF4 whose two low bits match a port.
- R7: A write to port i leaves the other three registers unchanged, and at most one port select is active in any cycle.
- R8: When the read and write strobes are high together, the write is performed, and the read data is forced to 0xFF for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 8 | Port address |
| busWrData | input | 8 | Data to store on a write |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busRdData | output | 8 | Read result; 0xFF when no port responds |

## Verification
The bench probes addresses just outside the group (0xF7, 0xFC) and 0xF4, which shares low bits with a port. A decoder that used only the low bits, or compared too few upper bits, would alias these onto a port: it would return register data instead of 0xFF, or corrupt a port on a stray write.

After each write, the bench reads back all four ports to catch a select that is not one-hot. That fault would smear one write across several registers.

The bench also drives both strobes high together. A design without write priority would either drop the store or leak register data onto the read output.

Finally, the bench checks the read result in the same cycle the address is applied. Any pipelining of the read path would show stale or 0xFF data there.

// File: rtl/pmio_pkg.sv
package pmio_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int PORT_CNT  = 4;
  localparam int SEL_W     = $clog2(PORT_CNT);
  localparam logic [ADDR_W-1:0] BASE_ADDR = 8'hF8;
  localparam int GROUP_W   = ADDR_W - SEL_W;

  typedef struct packed {
    logic [PORT_CNT-1:0] portHit;
    logic                writeGo;
    logic                readGo;
  } ctrlStrobes_t;
endpackage

// File: rtl/pmio_ctrl.sv
module pmio_ctrl
  import pmio_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output ctrlStrobes_t      strobes
);
  logic                groupHit;
  logic [PORT_CNT-1:0] hitVec;

  // Upper bits pick the group, lower bits pick the port inside it.
  assign groupHit = (busAddr[ADDR_W-1:SEL_W] == BASE_ADDR[ADDR_W-1:SEL_W]);

  for (genvar i = 0; i < PORT_CNT; i++) begin : g_sel
    assign hitVec[i] = groupHit && (busAddr[SEL_W-1:0] == SEL_W'(i));
  end

  always_comb begin
    strobes.portHit = hitVec;
    strobes.writeGo = busWr && groupHit;
    // Write has priority: a read while writing is suppressed.
    strobes.readGo  = busRd && !busWr && groupHit;
  end
endmodule

// File: rtl/pmio_datapath.sv
module pmio_datapath
  import pmio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);
  logic [DATA_W-1:0] portReg [PORT_CNT];
  logic [DATA_W-1:0] muxOut;

  for (genvar i = 0; i < PORT_CNT; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)
        portReg[i] <= '0;
      else if (strobes.writeGo && strobes.portHit[i])
        portReg[i] <= busWrData;
    end
  end

  // AND-OR multiplexer stands in for tri-state drivers.
  always_comb begin
    muxOut = '0;
    for (int i = 0; i < PORT_CNT; i++)
      if (strobes.portHit[i]) muxOut = muxOut | portReg[i];
  end

  assign busRdData = strobes.readGo ? muxOut : '1;
endmodule

// File: rtl/pmio_decoder.sv
module pmio_decoder
  import pmio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [DATA_W-1:0] busRdData
);
  ctrlStrobes_t strobes;

  pmio_ctrl u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strobes (strobes)
  );

  pmio_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .busWrData (busWrData),
    .busRdData (busRdData)
  );
endmodule

// File: rtl/pmio_decoder_chk.sv
module pmio_decoder_chk
  import pmio_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busRdData,
  input ctrlStrobes_t      strobes
);
  logic mapped;
  assign mapped = (busAddr >= BASE_ADDR) &&
                  (busAddr <= BASE_ADDR + ADDR_W'(PORT_CNT - 1));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) && !rst && busRd && !busWr && mapped |-> busRdData == '0);

  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(busWr) && $past(mapped) && busRd && !busWr &&
    busAddr == $past(busAddr) |-> busRdData == $past(busWrData));

  assert_unmapped_ff_R4: assert property (@(posedge clk) disable iff (rst)
    busRd && !mapped |-> busRdData == '1);

  assert_idle_ff_R5: assert property (@(posedge clk) disable iff (rst)
    !busRd |-> busRdData == '1);

  assert_onehot_sel_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes.portHit));

  assert_collide_ff_R8: assert property (@(posedge clk) disable iff (rst)
    busRd && busWr |-> busRdData == '1);
endmodule

bind pmio_decoder pmio_decoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busRd     (busRd),
  .busWr     (busWr),
  .busRdData (busRdData),
  .strobes   (strobes)
);

// File: tb/pmio_decoder_tb.sv
module pmio_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] expQ [$];
  string      tagQ [$];
  logic [7:0] model [4];

  always #10 clk = ~clk;   // 50 MHz

  pmio_decoder u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busRdData(busRdData)
  );

  function automatic bit inGroup(input logic [7:0] a);
    return (a >= 8'hF8) && (a <= 8'hFB);
  endfunction

  // Driver: applies one bus cycle at a falling edge and queues the expected read data.
  task automatic busCycle(input logic rd, input logic wr, input logic [7:0] a,
                          input logic [7:0] d, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = a; busWrData = d;
    exp = (rd && !wr && inGroup(a)) ? model[a[1:0]] : 8'hFF;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    if (wr && inGroup(a)) model[a[1:0]] = d;
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < 4; i++) busCycle(1'b1, 1'b0, 8'hF8 + 8'(i), 8'h00, tag);
  endtask

  // Monitor: samples mid-cycle, away from either clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (busRdData !== e) begin
          errors++;
          $display("FAIL %s: addr=%h got %h expected %h", t, busAddr, busRdData, e);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    readAll("R1 reset value");
    busCycle(1'b0, 1'b0, 8'hF9, 8'h00, "R5 idle bus");
    busCycle(1'b0, 1'b0, 8'h10, 8'h00, "R5 idle bus");

    busCycle(1'b0, 1'b1, 8'hF8, 8'h11, "R2 write strobe idle read");
    busCycle(1'b0, 1'b1, 8'hF9, 8'h22, "R2 write strobe idle read");
    busCycle(1'b0, 1'b1, 8'hFA, 8'h33, "R2 write strobe idle read");
    busCycle(1'b0, 1'b1, 8'hFB, 8'h44, "R2 write strobe idle read");
    readAll("R2 R3 readback");

    busCycle(1'b0, 1'b1, 8'hF9, 8'hA5, "R7 single write");
    readAll("R7 neighbours unchanged");
    busCycle(1'b0, 1'b1, 8'hFB, 8'h3C, "R2 back-to-back write");
    busCycle(1'b1, 1'b0, 8'hFB, 8'h00, "R3 read next cycle");

    busCycle(1'b1, 1'b0, 8'h00, 8'h00, "R4 unmapped read");
    busCycle(1'b1, 1'b0, 8'hF7, 8'h00, "R4 unmapped read");
    busCycle(1'b1, 1'b0, 8'hFC, 8'h00, "R4 unmapped read");
    busCycle(1'b1, 1'b0, 8'hFF, 8'h00, "R4 unmapped read");
    busCycle(1'b1, 1'b0, 8'hF4, 8'h00, "R4 alias read");
    busCycle(1'b1, 1'b0, 8'h78, 8'h00, "R4 alias read");

    busCycle(1'b0, 1'b1, 8'hFC, 8'h99, "R6 unmapped write");
    busCycle(1'b0, 1'b1, 8'hF4, 8'h77, "R6 alias write");
    busCycle(1'b0, 1'b1, 8'h7A, 8'h66, "R6 alias write");
    busCycle(1'b0, 1'b1, 8'hF7, 8'h55, "R6 unmapped write");
    readAll("R6 ports unchanged");

    busCycle(1'b1, 1'b1, 8'hFA, 8'h5A, "R8 collide read data");
    busCycle(1'b1, 1'b0, 8'hFA, 8'h00, "R8 write took effect");
    busCycle(1'b1, 1'b1, 8'hFD, 8'hC3, "R8 collide unmapped");
    readAll("R8 R6 after collide");

    busCycle(1'b0, 1'b0, 8'h00, 8'h00, "R5 idle bus");
    busCycle(1'b0, 1'b0, 8'h00, 8'h00, "R5 idle bus");
    wait (expQ.size() == 0);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule